// File: doc/BRIEF.md
# Configuration IDSEL Decoder with Private Line Masking

This block forms the secondary-side address word of a Type 0 configuration cycle inside a PCI-to-PCI bridge. It takes requests from two sources. The first is a Type 1 request forwarded from the primary side. It carries a 5-bit device number, which the block decodes to a single IDSEL line in the upper part of the address word. The second is a local translation unit that configures hidden devices. It names one of fifteen private-capable IDSEL lines by a 4-bit index.

A 10-bit mask register, written and read through a small register port, can withhold individual public lines from primary-originated conversions. A withheld line, together with the five low lines that are always reserved, can then be used only by the local unit. A primary request that lands on a withheld line still produces a Type 0 word, but with no IDSEL line set, so no device claims the cycle. A private request that names a line the mask has not freed is rejected with a one-cycle error pulse.

The word is registered one clock after a request is accepted. Function and register numbers pass through unchanged, and the type bits are zero.

Top module: `cfg_idsel_gen`

## Requirements
- R1: After synchronous reset, the mask reads back as zero, and `out_valid` and `prv_err` are low.
- R2: A primary request for device d in 0..15 with its line unmasked gives exactly one IDSEL bit, at address bit 16+d.
- R3: A primary request for device 16..31 is still completed (`out_valid` pulses) with every bit of `out_word[31:11]` zero.
- R4: A primary-originated word never sets any of `out_word[15:11]`.
- R5: Mask bit b, for b in 0..9, governs address bit 25-b. When it is set, a primary request for device 9-b yields a valid word with all IDSEL bits zero and no error.
- R6: Devices 10..15 (address bits 26..31) are decoded normally whatever the mask holds.
- R7: A private request with index 0..4 sets only address bit 11+index and is always accepted.
- R8: A private request with index 5..14 sets only address bit 11+index, and only if mask bit 14-index is set. Otherwise, and for index 15, it gives a one-cycle `prv_err` pulse and no `out_valid`.
- R9: In every word, bits [1:0] are 00, bits [10:8] carry the function number and bits [7:2] carry the register number.
- R10: `out_valid` (or `prv_err`) rises one clock after the request is accepted and lasts one cycle for one request. `out_src` is 0 for a primary word and 1 for a private word.
- R11: When both sources request in the same cycle, the primary request is served and `prv_ready` is low. A private request is taken only in a cycle with `prv_ready` high.
- R12: A mask write is readable on `reg_rdata` the cycle after. A request accepted in the same cycle as the write is decoded with the previous mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Mask register write strobe |
| reg_wdata | input | 10 | Mask write value |
| reg_rdata | output | 10 | Current mask value |
| pri_valid | input | 1 | Primary Type 1 request present |
| pri_dev | input | 5 | Primary device number |
| pri_func | input | 3 | Primary function number |
| pri_regn | input | 6 | Primary register number |
| prv_valid | input | 1 | Private request present |
| prv_ready | output | 1 | Private request taken this cycle when high |
| prv_idx | input | 4 | Private line index |
| prv_func | input | 3 | Private function number |
| prv_regn | input | 6 | Private register number |
| out_valid | output | 1 | Type 0 address word valid |
| out_src | output | 1 | Source of the word: 0 primary, 1 private |
| out_word | output | 32 | Type 0 address word |
| prv_err | output | 1 | Private request rejected |

## Verification
The hardest case to reach is a private request on a maskable line that succeeds. It needs a mask write first, and then a request whose index matches the freed line. The bench pairs the mask value with the request in each vector, so that freed and unfreed lines alternate and the same line is tried both ways. Two timing cases need exact cycle placement and are handled by directed tests. In the first, both sources request in the same cycle. In the second, a mask write and a request fall in the same cycle.

// File: rtl/cfg_idsel_pkg.sv
package cfg_idsel_pkg;

    localparam int DEV_W     = 5;
    localparam int PRV_W     = 4;
    localparam int FUNC_W    = 3;
    localparam int REGN_W    = 6;
    localparam int MASK_N    = 10;
    localparam int RSV_N     = 5;
    localparam int PUB_N     = 16;
    localparam int IDSEL_N   = RSV_N + PUB_N;
    localparam int PRV_LINES = RSV_N + MASK_N;
    localparam int WORD_W    = IDSEL_N + FUNC_W + REGN_W + 2;

    typedef enum logic {
        SRC_PRI = 1'b0,
        SRC_PRV = 1'b1
    } src_e;

    typedef struct packed {
        src_e              src;
        logic [DEV_W-1:0]  sel;
        logic [FUNC_W-1:0] func;
        logic [REGN_W-1:0] regn;
    } req_t;

    typedef struct packed {
        logic [IDSEL_N-1:0] idsel;
        logic [FUNC_W-1:0]  func;
        logic [REGN_W-1:0]  regn;
        logic [1:0]         kind;
    } cfg_word_t;

    // Primary device number to IDSEL line, with masked lines withheld.
    function automatic logic [IDSEL_N-1:0] pri_decode(
        input logic [DEV_W-1:0]  dev,
        input logic [MASK_N-1:0] mask
    );
        logic [IDSEL_N-1:0] v;
        v = '0;
        for (int d = 0; d < PUB_N; d++) begin
            if (dev == DEV_W'(d)) v[RSV_N + d] = 1'b1;
        end
        for (int b = 0; b < MASK_N; b++) begin
            if (mask[b]) v[RSV_N + MASK_N - 1 - b] = 1'b0;
        end
        return v;
    endfunction

    // Private index to IDSEL line (bit i of the field is address bit 11+i).
    function automatic logic [IDSEL_N-1:0] prv_decode(input logic [PRV_W-1:0] idx);
        logic [IDSEL_N-1:0] v;
        v = '0;
        for (int i = 0; i < PRV_LINES; i++) begin
            if (idx == PRV_W'(i)) v[i] = 1'b1;
        end
        return v;
    endfunction

    // A private index is legal on a reserved line or on a line freed by the mask.
    function automatic logic prv_allowed(
        input logic [PRV_W-1:0]  idx,
        input logic [MASK_N-1:0] mask
    );
        logic ok;
        ok = 1'b0;
        for (int i = 0; i < RSV_N; i++) begin
            if (idx == PRV_W'(i)) ok = 1'b1;
        end
        for (int b = 0; b < MASK_N; b++) begin
            if (mask[b] && idx == PRV_W'(PRV_LINES - 1 - b)) ok = 1'b1;
        end
        return ok;
    endfunction

endpackage

// File: rtl/idsel_mask_reg.sv
module idsel_mask_reg
    import cfg_idsel_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [MASK_N-1:0] wdata,
    output logic [MASK_N-1:0] mask,
    output logic [MASK_N-1:0] rdata
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mask <= '0;
        end else if (wr_en) begin
            mask <= wdata;
        end
    end

    assign rdata = mask;

    // R12
    mask_wr_visible_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> rdata == $past(wdata));

endmodule

// File: rtl/idsel_req_arb.sv
module idsel_req_arb
    import cfg_idsel_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              pri_valid,
    input  logic [DEV_W-1:0]  pri_dev,
    input  logic [FUNC_W-1:0] pri_func,
    input  logic [REGN_W-1:0] pri_regn,
    input  logic              prv_valid,
    input  logic [PRV_W-1:0]  prv_idx,
    input  logic [FUNC_W-1:0] prv_func,
    input  logic [REGN_W-1:0] prv_regn,
    output logic              prv_ready,
    output logic              grant_valid,
    output req_t              grant
);

    assign prv_ready   = !pri_valid;
    assign grant_valid = pri_valid || prv_valid;

    always_comb begin
        if (pri_valid) begin
            grant.src  = SRC_PRI;
            grant.sel  = pri_dev;
            grant.func = pri_func;
            grant.regn = pri_regn;
        end else begin
            grant.src  = SRC_PRV;
            grant.sel  = DEV_W'(prv_idx);
            grant.func = prv_func;
            grant.regn = prv_regn;
        end
    end

    // R11
    pri_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (pri_valid && prv_valid) |-> (grant.src == SRC_PRI && grant.sel == pri_dev));

endmodule

// File: rtl/idsel_word_build.sv
module idsel_word_build
    import cfg_idsel_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              grant_valid,
    input  req_t              grant,
    input  logic [MASK_N-1:0] mask,
    output logic              out_valid,
    output src_e              out_src,
    output cfg_word_t         out_word,
    output logic              prv_err
);

    logic [IDSEL_N-1:0] idsel_nx;
    logic               reject;

    always_comb begin
        if (grant.src == SRC_PRV) begin
            idsel_nx = prv_decode(grant.sel[PRV_W-1:0]);
            reject   = !prv_allowed(grant.sel[PRV_W-1:0], mask);
        end else begin
            idsel_nx = pri_decode(grant.sel, mask);
            reject   = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            prv_err   <= 1'b0;
            out_src   <= SRC_PRI;
            out_word  <= '0;
        end else begin
            out_valid <= 1'b0;
            prv_err   <= 1'b0;
            if (grant_valid) begin
                if (reject) begin
                    prv_err <= 1'b1;
                end else begin
                    out_valid      <= 1'b1;
                    out_src        <= grant.src;
                    out_word.idsel <= idsel_nx;
                    out_word.func  <= grant.func;
                    out_word.regn  <= grant.regn;
                    out_word.kind  <= 2'b00;
                end
            end
        end
    end

    // R2
    idsel_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $onehot0(out_word.idsel));

    // R9
    type0_kind_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_word.kind == 2'b00);

    // R4
    rsv_lines_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_src == SRC_PRI) |-> out_word.idsel[RSV_N-1:0] == '0);

    // R8
    err_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(out_valid && prv_err));

    // R10
    resp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid || prv_err) |-> $past(grant_valid));

endmodule

// File: rtl/cfg_idsel_gen.sv
module cfg_idsel_gen
    import cfg_idsel_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr_en,
    input  logic [MASK_N-1:0] reg_wdata,
    output logic [MASK_N-1:0] reg_rdata,
    input  logic              pri_valid,
    input  logic [DEV_W-1:0]  pri_dev,
    input  logic [FUNC_W-1:0] pri_func,
    input  logic [REGN_W-1:0] pri_regn,
    input  logic              prv_valid,
    output logic              prv_ready,
    input  logic [PRV_W-1:0]  prv_idx,
    input  logic [FUNC_W-1:0] prv_func,
    input  logic [REGN_W-1:0] prv_regn,
    output logic              out_valid,
    output logic              out_src,
    output logic [WORD_W-1:0] out_word,
    output logic              prv_err
);

    logic [MASK_N-1:0] mask;
    logic              grant_valid;
    req_t              grant;
    src_e              src_q;
    cfg_word_t         word_q;

    idsel_mask_reg u_mask (
        .clk   (clk),
        .rst   (rst),
        .wr_en (reg_wr_en),
        .wdata (reg_wdata),
        .mask  (mask),
        .rdata (reg_rdata)
    );

    idsel_req_arb u_arb (
        .clk         (clk),
        .rst         (rst),
        .pri_valid   (pri_valid),
        .pri_dev     (pri_dev),
        .pri_func    (pri_func),
        .pri_regn    (pri_regn),
        .prv_valid   (prv_valid),
        .prv_idx     (prv_idx),
        .prv_func    (prv_func),
        .prv_regn    (prv_regn),
        .prv_ready   (prv_ready),
        .grant_valid (grant_valid),
        .grant       (grant)
    );

    idsel_word_build u_build (
        .clk         (clk),
        .rst         (rst),
        .grant_valid (grant_valid),
        .grant       (grant),
        .mask        (mask),
        .out_valid   (out_valid),
        .out_src     (src_q),
        .out_word    (word_q),
        .prv_err     (prv_err)
    );

    assign out_src  = src_q;
    assign out_word = word_q;

endmodule

// File: tb/cfg_idsel_gen_tb.sv
`timescale 1ns/1ps
module cfg_idsel_gen_tb;

    typedef struct packed {
        logic        prv;
        logic [4:0]  sel;
        logic [9:0]  mask;
        logic [20:0] idsel;
        logic        err;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 5'd0,  10'h000, 21'h000020, 1'b0},
        '{1'b0, 5'd9,  10'h000, 21'h004000, 1'b0},
        '{1'b0, 5'd15, 10'h000, 21'h100000, 1'b0},
        '{1'b0, 5'd16, 10'h000, 21'h000000, 1'b0},
        '{1'b0, 5'd31, 10'h000, 21'h000000, 1'b0},
        '{1'b0, 5'd0,  10'h200, 21'h000000, 1'b0},
        '{1'b0, 5'd9,  10'h001, 21'h000000, 1'b0},
        '{1'b0, 5'd1,  10'h200, 21'h000040, 1'b0},
        '{1'b0, 5'd10, 10'h3FF, 21'h008000, 1'b0},
        '{1'b0, 5'd5,  10'h3FF, 21'h000000, 1'b0},
        '{1'b1, 5'd0,  10'h000, 21'h000001, 1'b0},
        '{1'b1, 5'd4,  10'h000, 21'h000010, 1'b0},
        '{1'b1, 5'd5,  10'h200, 21'h000020, 1'b0},
        '{1'b1, 5'd5,  10'h000, 21'h000000, 1'b1},
        '{1'b1, 5'd14, 10'h001, 21'h004000, 1'b0},
        '{1'b1, 5'd14, 10'h002, 21'h000000, 1'b1},
        '{1'b1, 5'd15, 10'h3FF, 21'h000000, 1'b1},
        '{1'b0, 5'd3,  10'h040, 21'h000000, 1'b0},
        '{1'b1, 5'd8,  10'h040, 21'h000100, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_wr_en;
    logic [9:0]  reg_wdata;
    logic [9:0]  reg_rdata;
    logic        pri_valid;
    logic [4:0]  pri_dev;
    logic [2:0]  pri_func;
    logic [5:0]  pri_regn;
    logic        prv_valid;
    logic        prv_ready;
    logic [3:0]  prv_idx;
    logic [2:0]  prv_func;
    logic [5:0]  prv_regn;
    logic        out_valid;
    logic        out_src;
    logic [31:0] out_word;
    logic        prv_err;

    int errs = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    cfg_idsel_gen u_dut (
        .clk (clk), .rst (rst),
        .reg_wr_en (reg_wr_en), .reg_wdata (reg_wdata), .reg_rdata (reg_rdata),
        .pri_valid (pri_valid), .pri_dev (pri_dev), .pri_func (pri_func), .pri_regn (pri_regn),
        .prv_valid (prv_valid), .prv_ready (prv_ready), .prv_idx (prv_idx),
        .prv_func (prv_func), .prv_regn (prv_regn),
        .out_valid (out_valid), .out_src (out_src), .out_word (out_word), .prv_err (prv_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_inputs();
        reg_wr_en = 1'b0; reg_wdata = '0;
        pri_valid = 1'b0; pri_dev = '0; pri_func = '0; pri_regn = '0;
        prv_valid = 1'b0; prv_idx = '0; prv_func = '0; prv_regn = '0;
    endtask

    task automatic write_mask(input logic [9:0] m);
        @(negedge clk);
        reg_wr_en = 1'b1;
        reg_wdata = m;
        @(negedge clk);
        reg_wr_en = 1'b0;
        chk("R12 readback", 32'(reg_rdata), 32'(m));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        clear_inputs();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk("R1 mask", 32'(reg_rdata), 32'h0);
        chk("R1 out_valid", 32'(out_valid), 32'h0);
        chk("R1 prv_err", 32'(prv_err), 32'h0);

        for (int i = 0; i < NV; i++) begin
            vec_t        v;
            logic [2:0]  f;
            logic [5:0]  r;
            string       tag;
            v = VECS[i];
            f = 3'(i % 8);
            r = 6'((i * 7 + 3) % 64);
            if (v.prv) tag = (v.err || v.sel >= 5) ? "R8" : "R7";
            else if (v.sel >= 16) tag = "R3";
            else if (v.sel >= 10) tag = "R6";
            else if (v.idsel == '0) tag = "R5";
            else tag = "R2";
            write_mask(v.mask);
            if (v.prv) begin
                prv_valid = 1'b1; prv_idx = v.sel[3:0]; prv_func = f; prv_regn = r;
                #1;
                chk("R11 ready alone", 32'(prv_ready), 32'h1);
            end else begin
                pri_valid = 1'b1; pri_dev = v.sel; pri_func = f; pri_regn = r;
            end
            @(negedge clk);
            clear_inputs();
            chk({tag, " valid"}, 32'(out_valid), 32'(!v.err));
            chk({tag, " err"}, 32'(prv_err), 32'(v.err));
            if (!v.err) begin
                chk({tag, " idsel"}, 32'(out_word[31:11]), 32'(v.idsel));
                chk("R9 word", out_word, {v.idsel, f, r, 2'b00});
                chk("R10 src", 32'(out_src), 32'(v.prv));
                if (!v.prv) chk("R4 reserved", 32'(out_word[15:11]), 32'h0);
            end
            @(negedge clk);
            chk("R10 pulse", 32'({out_valid, prv_err}), 32'h0);
        end

        // R11: simultaneous requests, primary first
        write_mask(10'h000);
        @(negedge clk);
        pri_valid = 1'b1; pri_dev = 5'd2; pri_func = 3'd5; pri_regn = 6'd9;
        prv_valid = 1'b1; prv_idx = 4'd3; prv_func = 3'd1; prv_regn = 6'd4;
        #1;
        chk("R11 ready blocked", 32'(prv_ready), 32'h0);
        @(negedge clk);
        pri_valid = 1'b0;
        chk("R11 primary served", out_word, {21'h000080, 3'd5, 6'd9, 2'b00});
        chk("R11 primary src", 32'(out_src), 32'h0);
        #1;
        chk("R11 ready after", 32'(prv_ready), 32'h1);
        @(negedge clk);
        clear_inputs();
        chk("R11 private served", out_word, {21'h000008, 3'd1, 6'd4, 2'b00});
        chk("R11 private src", 32'(out_src), 32'h1);

        // R12: write and request in the same cycle use the old mask
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wdata = 10'h200;
        pri_valid = 1'b1; pri_dev = 5'd0; pri_func = 3'd0; pri_regn = 6'd0;
        @(negedge clk);
        reg_wr_en = 1'b0;
        chk("R12 old mask used", 32'(out_word[31:11]), 32'h20);
        @(negedge clk);
        clear_inputs();
        chk("R12 new mask used", 32'(out_word[31:11]), 32'h0);
        chk("R12 new mask valid", 32'(out_valid), 32'h1);

        @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule